// File: doc/BRIEF.md
# Control Register Write Validator

This block keeps the system control registers of a 64-bit core: CR0, CR2, CR3, CR4, CR8 and an extended feature register. It has one write port and one read port. The write port takes a register index, a 64-bit value, a strobe and a flag that says whether the core is in long mode. A write is tested against legality rules in the same cycle. It commits at that clock edge only when it is legal. An illegal write changes nothing. The block answers it one cycle later with a fault pulse that carries a cause code. A general-protection cause always implies an error code of zero.

The rules look across registers. Some CR0 writes are judged against the current CR4 and the long-mode-enable bit of the feature register. CR4 writes are judged against the operating mode. A committed CR0 write that flips paging while long-mode enable is set also updates the long-mode-active bit of the feature register. Software cannot write the feature register here. Its value comes from a reset parameter, and only the long-mode-active side effect changes it afterwards. The read port is combinational and reads the register chosen by an index. The feature register has an output of its own.

Top module: `cr_write_guard`

## Requirements
- R1: After reset CR0 reads 0x10, CR2, CR3, CR4 and CR8 read zero, and the feature register holds the parameter FEAT_RESET.
- R2: A write to index 1, 5, 6, 7 or any index from 9 up raises cause 1 (invalid opcode) and changes no register.
- R3: A read of an index other than 0, 2, 3, 4 or 8 returns zero.
- R4: A CR0 write with any of bits 63:32 set raises cause 2 (general protection) and changes no register.
- R5: A CR0 write with bit 31 (paging) set and bit 0 (protection) clear raises cause 2.
- R6: A CR0 write with bit 29 (not-write-through) set and bit 30 (cache disable) clear raises cause 2.
- R7: A CR0 write with bit 31 set raises cause 2 while feature bit 8 (long-mode enable) is set and the current CR4 has bit 5 (PAE) clear.
- R8: A CR4 write raises cause 2 when any of bits 63:11 is set, or when the long-mode input is high and bit 5 of the new value is clear.
- R9: A CR8 write raises cause 2 when any of bits 63:4 is set. Otherwise it commits.
- R10: A write to CR2 or CR3 commits any 64-bit value with no fault.
- R11: A committed CR0 write that changes bit 31 while feature bit 8 is set copies the new bit 31 into feature bit 10 (long-mode active). The other feature bits never change.
- R12: CR0 bit 4 reads 1 after every committed CR0 write, whatever value was supplied.
- R13: The fault outputs are registered. In the cycle after a strobe, faultValid pulses for one cycle with cause 1 or 2. A legal write gives no pulse, and no pulse appears in a cycle that follows no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrIdx | input | IDX_W | Index of the register to write |
| wrData | input | DATA_W | New register value |
| longMode | input | 1 | High while the core runs in long mode |
| rdIdx | input | IDX_W | Read index |
| rdData | output | DATA_W | Value of the register chosen by rdIdx, or zero |
| featOut | output | DATA_W | Extended feature register |
| faultValid | output | 1 | One-cycle fault pulse |
| faultCause | output | 2 | 0 none, 1 invalid opcode, 2 general protection |

## Verification
The hardest case to reach from the ports is the long-mode-active update. It needs long-mode enable set at reset, and CR4 must already hold PAE, because a paging write made without PAE faults first. The bench therefore builds the block with long-mode enable in its reset value and commits CR4 with PAE. It then turns paging on and off, and each time it reads the feature register back. Every write, legal or not, is followed by a readback of all sixteen indices against a model. This shows that a faulting write left every register as it was.

// File: rtl/crw_pkg.sv
package crw_pkg;

  // Bit positions inside CR0
  localparam int Cr0Pe = 0;
  localparam int Cr0Et = 4;
  localparam int Cr0Nw = 29;
  localparam int Cr0Cd = 30;
  localparam int Cr0Pg = 31;
  // Bit position inside CR4
  localparam int Cr4Pae = 5;
  // Bit positions inside the extended feature register
  localparam int FeatLme = 8;
  localparam int FeatLma = 10;

  // Lowest reserved bit of each checked register
  localparam int Cr0ResLsb = 32;
  localparam int Cr4ResLsb = 11;
  localparam int Cr8ResLsb = 4;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_UD   = 2'd1,
    CAUSE_GP   = 2'd2
  } faultCause_e;

  typedef struct packed {
    logic loadCr0;
    logic loadCr2;
    logic loadCr3;
    logic loadCr4;
    logic loadCr8;
    logic lmaWrite;
    logic lmaValue;
  } wrStrobes_t;

endpackage

// File: rtl/crw_ctrl.sv
module crw_ctrl
  import crw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              longMode,
  input  logic              curCr0Pg,
  input  logic              curCr4Pae,
  input  logic              curFeatLme,
  output wrStrobes_t        strobes,
  output logic              faultValid,
  output logic [1:0]        faultCause
);

  localparam logic [IDX_W-1:0] IdxCr0 = IDX_W'(0);
  localparam logic [IDX_W-1:0] IdxCr2 = IDX_W'(2);
  localparam logic [IDX_W-1:0] IdxCr3 = IDX_W'(3);
  localparam logic [IDX_W-1:0] IdxCr4 = IDX_W'(4);
  localparam logic [IDX_W-1:0] IdxCr8 = IDX_W'(8);

  faultCause_e cause;
  faultCause_e causeQ;
  logic        validQ;
  logic        isImpl;
  logic        cr0Bad;
  logic        cr4Bad;
  logic        cr8Bad;
  logic        commit;
  logic        unusedBits;

  assign unusedBits = ^wrData;

  // Legality of the index
  always_comb begin
    case (wrIdx)
      IdxCr0, IdxCr2, IdxCr3, IdxCr4, IdxCr8: isImpl = 1'b1;
      default:                               isImpl = 1'b0;
    endcase
  end

  // Per-register value rules
  always_comb begin
    cr0Bad = (|wrData[DATA_W-1:Cr0ResLsb])
           | (wrData[Cr0Pg] & ~wrData[Cr0Pe])
           | (wrData[Cr0Nw] & ~wrData[Cr0Cd])
           | (wrData[Cr0Pg] & curFeatLme & ~curCr4Pae);
    cr4Bad = (|wrData[DATA_W-1:Cr4ResLsb])
           | (longMode & ~wrData[Cr4Pae]);
    cr8Bad = |wrData[DATA_W-1:Cr8ResLsb];
  end

  always_comb begin
    cause = CAUSE_NONE;
    if (!isImpl) begin
      cause = CAUSE_UD;
    end else if ((wrIdx == IdxCr0 && cr0Bad) ||
                 (wrIdx == IdxCr4 && cr4Bad) ||
                 (wrIdx == IdxCr8 && cr8Bad)) begin
      cause = CAUSE_GP;
    end
  end

  assign commit = wrEn && (cause == CAUSE_NONE);

  always_comb begin
    strobes          = '0;
    strobes.loadCr0  = commit && (wrIdx == IdxCr0);
    strobes.loadCr2  = commit && (wrIdx == IdxCr2);
    strobes.loadCr3  = commit && (wrIdx == IdxCr3);
    strobes.loadCr4  = commit && (wrIdx == IdxCr4);
    strobes.loadCr8  = commit && (wrIdx == IdxCr8);
    strobes.lmaWrite = strobes.loadCr0 && curFeatLme &&
                       (wrData[Cr0Pg] != curCr0Pg);
    strobes.lmaValue = wrData[Cr0Pg];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else begin
      validQ <= wrEn && (cause != CAUSE_NONE);
      causeQ <= wrEn ? cause : CAUSE_NONE;
    end
  end

  assign faultValid = validQ;
  assign faultCause = causeQ;

endmodule

// File: rtl/crw_datapath.sv
module crw_datapath
  import crw_pkg::*;
#(
  parameter int              DATA_W     = 64,
  parameter int              IDX_W      = 4,
  parameter logic [DATA_W-1:0] FEAT_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] featOut,
  output logic              curCr0Pg,
  output logic              curCr4Pae,
  output logic              curFeatLme
);

  localparam logic [DATA_W-1:0] EtMask    = DATA_W'(1) << Cr0Et;
  localparam logic [DATA_W-1:0] Cr0Reset  = EtMask;

  logic [DATA_W-1:0] cr0Q;
  logic [DATA_W-1:0] cr2Q;
  logic [DATA_W-1:0] cr3Q;
  logic [DATA_W-1:0] cr4Q;
  logic [DATA_W-1:0] cr8Q;
  logic [DATA_W-1:0] featQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr0Q  <= Cr0Reset;
      cr2Q  <= '0;
      cr3Q  <= '0;
      cr4Q  <= '0;
      cr8Q  <= '0;
      featQ <= FEAT_RESET;
    end else begin
      if (strobes.loadCr0) cr0Q <= wrData | EtMask;
      if (strobes.loadCr2) cr2Q <= wrData;
      if (strobes.loadCr3) cr3Q <= wrData;
      if (strobes.loadCr4) cr4Q <= wrData;
      if (strobes.loadCr8) cr8Q <= wrData;
      if (strobes.lmaWrite) featQ[FeatLma] <= strobes.lmaValue;
    end
  end

  always_comb begin
    case (rdIdx)
      IDX_W'(0): rdData = cr0Q;
      IDX_W'(2): rdData = cr2Q;
      IDX_W'(3): rdData = cr3Q;
      IDX_W'(4): rdData = cr4Q;
      IDX_W'(8): rdData = cr8Q;
      default:   rdData = '0;
    endcase
  end

  assign featOut    = featQ;
  assign curCr0Pg   = cr0Q[Cr0Pg];
  assign curCr4Pae  = cr4Q[Cr4Pae];
  assign curFeatLme = featQ[FeatLme];

endmodule

// File: rtl/cr_write_guard.sv
module cr_write_guard
  import crw_pkg::*;
#(
  parameter int                DATA_W     = 64,
  parameter int                IDX_W      = 4,
  parameter logic [DATA_W-1:0] FEAT_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              longMode,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] featOut,
  output logic              faultValid,
  output logic [1:0]        faultCause
);

  wrStrobes_t strobes;
  logic       curCr0Pg;
  logic       curCr4Pae;
  logic       curFeatLme;

  crw_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) ctrlInst (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .longMode   (longMode),
    .curCr0Pg   (curCr0Pg),
    .curCr4Pae  (curCr4Pae),
    .curFeatLme (curFeatLme),
    .strobes    (strobes),
    .faultValid (faultValid),
    .faultCause (faultCause)
  );

  crw_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W), .FEAT_RESET(FEAT_RESET)) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .featOut    (featOut),
    .curCr0Pg   (curCr0Pg),
    .curCr4Pae  (curCr4Pae),
    .curFeatLme (curFeatLme)
  );

endmodule

// File: rtl/cr_write_guard_chk.sv
module cr_write_guard_chk #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] featOut,
  input logic              faultValid,
  input logic [1:0]        faultCause
);

  localparam logic [DATA_W-1:0] KeepMask = ~(DATA_W'(1) << 10);

  function automatic logic isImpl(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(0)) || (idx == IDX_W'(2)) || (idx == IDX_W'(3)) ||
           (idx == IDX_W'(4)) || (idx == IDX_W'(8));
  endfunction

  // R2
  ud_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !isImpl(wrIdx) |=> faultValid && faultCause == 2'd1);

  // R3
  rd_unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isImpl(rdIdx) |-> rdData == '0);

  // R4
  cr0_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrIdx == IDX_W'(0) && (|wrData[DATA_W-1:32]) |=> faultValid && faultCause == 2'd2);

  // R9
  cr8_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrIdx == IDX_W'(8) && (|wrData[DATA_W-1:4]) |=> faultValid && faultCause == 2'd2);

  // R10
  cr23_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrIdx == IDX_W'(2) || wrIdx == IDX_W'(3)) |=> !faultValid);

  // R11
  feat_other_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(featOut & KeepMask));

  // R12
  et_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdIdx == IDX_W'(0) |-> rdData[4]);

  // R13
  no_spurious_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !faultValid);

  // R13
  cause_valid_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> faultCause == 2'd1 || faultCause == 2'd2);

endmodule

bind cr_write_guard cr_write_guard_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrIdx      (wrIdx),
  .wrData     (wrData),
  .rdIdx      (rdIdx),
  .rdData     (rdData),
  .featOut    (featOut),
  .faultValid (faultValid),
  .faultCause (faultCause)
);

// File: tb/cr_write_guard_test.sv
`timescale 1ns/1ps
module cr_write_guard_test;

  localparam int DW = 64;
  localparam int IW = 4;
  localparam logic [DW-1:0] FeatInit = 64'h100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [IW-1:0] wrIdx = '0;
  logic [DW-1:0] wrData = '0;
  logic          longMode = 1'b0;
  logic [IW-1:0] rdIdx = '0;
  logic [DW-1:0] rdData;
  logic [DW-1:0] featOut;
  logic          faultValid;
  logic [1:0]    faultCause;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [1:0] cause;
    string      req;
  } expItem_t;

  expItem_t expQ[$];

  // Model state
  logic [DW-1:0] mCr0 = 64'h10;
  logic [DW-1:0] mCr2 = '0;
  logic [DW-1:0] mCr3 = '0;
  logic [DW-1:0] mCr4 = '0;
  logic [DW-1:0] mCr8 = '0;
  logic [DW-1:0] mFeat = FeatInit;

  always #2 clk = ~clk;

  cr_write_guard #(.DATA_W(DW), .IDX_W(IW), .FEAT_RESET(FeatInit)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .longMode   (longMode),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .featOut    (featOut),
    .faultValid (faultValid),
    .faultCause (faultCause)
  );

  function automatic logic [DW-1:0] expRd(input int idx);
    case (idx)
      0: return mCr0;
      2: return mCr2;
      3: return mCr3;
      4: return mCr4;
      8: return mCr8;
      default: return '0;
    endcase
  endfunction

  task automatic check64(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reads every index and the feature register back against the model
  task automatic checkState(input string req);
    for (int i = 0; i < 16; i++) begin
      rdIdx = IW'(i);
      #0.2;
      check64(req, rdData, expRd(i));
    end
    check64(req, featOut, mFeat);
  endtask

  // Driver: one write, expected cause pushed to the scoreboard
  task automatic writeCr(input int idx, input logic [DW-1:0] data, input logic lm,
                         input logic [1:0] exp, input string req);
    expItem_t it;
    @(negedge clk);
    wrIdx = IW'(idx);
    wrData = data;
    longMode = lm;
    wrEn = 1'b1;
    it.cause = exp;
    it.req = req;
    expQ.push_back(it);
    if (exp == 2'd0) begin
      case (idx)
        0: begin
          if (mFeat[8] && (data[31] != mCr0[31])) mFeat[10] = data[31];
          mCr0 = data | 64'h10;
        end
        2: mCr2 = data;
        3: mCr3 = data;
        4: mCr4 = data;
        8: mCr8 = data;
        default: ;
      endcase
    end
    @(negedge clk);
    wrEn = 1'b0;
    checkState(req);
  endtask

  // Monitor: compares the fault pulse one cycle after each strobe
  initial begin
    logic sampled;
    expItem_t it;
    wait (rstN === 1'b1);
    forever begin
      @(posedge clk);
      sampled = wrEn;
      #1;
      if (sampled) begin
        it = expQ.pop_front();
        checks++;
        if (faultValid !== (it.cause != 2'd0) || faultCause !== it.cause) begin
          failures++;
          $display("FAIL %s R13 actual valid=%0b cause=%0d expected valid=%0b cause=%0d",
                   it.req, faultValid, faultCause, it.cause != 2'd0, it.cause);
        end
      end else if (faultValid !== 1'b0) begin
        checks++;
        failures++;
        $display("FAIL R13 pulse with no strobe actual=%0b expected=0", faultValid);
      end
    end
  end

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 reset");

    // R2 unimplemented indices
    writeCr(1, 64'h5, 1'b0, 2'd1, "R2 idx1");
    writeCr(6, 64'h0, 1'b0, 2'd1, "R2 idx6");
    writeCr(9, 64'h1, 1'b0, 2'd1, "R2 idx9");
    writeCr(15, 64'hFF, 1'b0, 2'd1, "R2 idx15");
    // R3 unimplemented reads covered in each checkState sweep

    // R4 high bits of CR0
    writeCr(0, 64'h1_0000_0001, 1'b0, 2'd2, "R4 cr0 high");
    // R5 paging without protection
    writeCr(0, 64'h8000_0000, 1'b0, 2'd2, "R5 pg no pe");
    // R6 NW without CD
    writeCr(0, 64'h2000_0001, 1'b0, 2'd2, "R6 nw no cd");
    // R6 and R12 legal NW with CD, ET supplied as zero
    writeCr(0, 64'h6000_0001, 1'b0, 2'd0, "R12 et forced");
    // R7 paging with LME set and PAE clear
    writeCr(0, 64'h8000_0001, 1'b0, 2'd2, "R7 pae missing");

    // R8 CR4 rules
    writeCr(4, 64'h800, 1'b0, 2'd2, "R8 cr4 reserved");
    writeCr(4, 64'h20, 1'b0, 2'd0, "R8 cr4 pae ok");

    // R11 paging on sets LMA
    writeCr(0, 64'h8000_0001, 1'b0, 2'd0, "R11 lma set");
    check64("R11 lma on", {63'b0, featOut[10]}, 64'h1);
    writeCr(0, 64'h8000_0003, 1'b0, 2'd0, "R11 pg unchanged");
    writeCr(4, 64'h0, 1'b1, 2'd2, "R8 long mode pae clear");
    writeCr(4, 64'h20, 1'b1, 2'd0, "R8 long mode pae kept");
    // R11 paging off clears LMA
    writeCr(0, 64'h1, 1'b0, 2'd0, "R11 lma clear");
    check64("R11 lma off", {63'b0, featOut[10]}, 64'h0);

    // R9 CR8
    writeCr(8, 64'h10, 1'b0, 2'd2, "R9 cr8 reserved");
    writeCr(8, 64'hF, 1'b0, 2'd0, "R9 cr8 ok");

    // R10 CR2 and CR3 take any value
    writeCr(2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, "R10 cr2");
    writeCr(3, 64'h1234_5678_9ABC_DEF0, 1'b1, 2'd0, "R10 cr3");
    writeCr(5, 64'h0, 1'b1, 2'd1, "R2 idx5");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R13 leftover items actual=%0d expected=0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule